// File: doc/BRIEF.md
# Private Hardware Stack for an 8-bit Core

This unit gives a small processor core a last-in, first-out store for status bytes, accumulator values and 16-bit return addresses. The store sits in its own RAM, outside the core's address space. Its depth is set by the parameter `DEPTH`, counted in bytes. The only way to change the stack pointer is to push or pull through the request port. No port reads the pointer and no port loads it.

The core sends a command on a valid/ready request channel, using the 2-bit operation field `req_op`:

- `01` pushes one byte, `req_data[7:0]`. This serves status or accumulator pushes.
- `10` pushes a 16-bit return address, `req_data`.
- `00` pulls one byte.
- `11` pulls a 16-bit address. A return from subroutine uses this command. A return from interrupt sends a byte pull followed by a word pull.

A pulled value leaves on a valid/ready response channel.

Back-pressure rules:
- A request is accepted on a rising clock edge where both `req_valid` and `req_ready` are high.
- `req_ready` is low while a two-byte transfer is in progress. `busy` is also high during that time.
- `req_ready` is also low while a response waits for the core.
- The response holds `rsp_valid` and `rsp_data` unchanged until an edge with `rsp_ready` high.

A command that would overflow or underflow the stack is dropped. It sets a sticky error flag instead, and those flags clear only on reset.

Top module: `hw_stack`

## Requirements
- R1: After reset the stack is empty, `req_ready` is 1, and `busy`, `rsp_valid`, `ovf_err` and `unf_err` are all 0.
- R2: Byte pushes (op `01`) and byte pulls (op `00`) behave last-in, first-out. A pulled byte appears on `rsp_data[7:0]` with `rsp_data[15:8]` = 0. A byte pull's response is valid in the cycle after acceptance.
- R3: A word push (op `10`) stores `req_data[15:8]` first and `req_data[7:0]` second. A word pull (op `11`) returns the two top bytes as {second byte read, first byte read}, so a word pull returns the pushed word unchanged. Two byte pulls after a word push return the low byte, then the high byte.
- R4: The stack holds exactly `DEPTH` bytes without an error.
- R5: A byte push with no free entry, or a word push with fewer than two free entries, sets `ovf_err`. It writes nothing and leaves the pointer unchanged. `ovf_err` rises only in the cycle after an accepted push.
- R6: A byte pull on an empty stack, or a word pull with fewer than two stored bytes, sets `unf_err`. It produces no response and leaves the contents unchanged. `unf_err` rises only in the cycle after an accepted pull.
- R7: `ovf_err` and `unf_err` stay set until reset.
- R8: After a word command is accepted, `busy` is 1 and `req_ready` is 0 until the second byte has been moved. For a word push that is exactly one cycle.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` and `rsp_data` hold steady and no new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Command can be accepted |
| req_op | input | 2 | 00 pull byte, 01 push byte, 10 push word, 11 pull word |
| req_data | input | 16 | Data to push; a byte push uses bits 7:0 |
| busy | output | 1 | Second byte of a word transfer still pending |
| rsp_valid | output | 1 | Pulled data present |
| rsp_ready | input | 1 | Core takes the pulled data |
| rsp_data | output | 16 | Pulled byte (zero-extended) or word |
| ovf_err | output | 1 | Sticky overflow flag |
| unf_err | output | 1 | Sticky underflow flag |

## Verification
For a depth of 8, the bench fills the stack to every level from empty to full. At each level it tries a word push and a byte push, then drains the stack byte by byte and pulls once more on an empty stack. This separates correct off-by-one bounds from wrong ones, and rejected commands from commands that corrupt memory. Word-only traffic at several depths, with byte distinct patterns, shows whether the high and low bytes are kept in the correct order. A word pull with a single byte stored checks that a rejected pull leaves that byte intact. Stalled responses and the busy window are checked cycle by cycle.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_PULL_B = 2'b00,
    OP_PUSH_B = 2'b01,
    OP_PUSH_W = 2'b10,
    OP_PULL_W = 2'b11
  } stk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PUSH_LO,
    ST_RD_HI,
    ST_RSP
  } stk_state_e;
endpackage

// File: rtl/stk_ram.sv
module stk_ram #(
  parameter int DEPTH = 64,
  parameter int BW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wd,
  output logic [BW-1:0] q
);
  logic [BW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int DEPTH = 64,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec,
  input  logic          inc,
  output logic [PW-1:0] sp,
  output logic          room1,
  output logic          room2,
  output logic          have1,
  output logic          have2
);
  localparam logic [PW-1:0] TOP  = PW'(DEPTH);
  localparam logic [PW-1:0] LIM2 = PW'(DEPTH - 2);
  localparam logic [PW-1:0] TWO  = PW'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sp <= TOP;
    else if (dec) sp <= sp - 1'b1;
    else if (inc) sp <= sp + 1'b1;
  end

  // the pointer counts down from TOP; TOP means empty, 0 means full
  assign room1 = (sp != '0);
  assign room2 = (sp >= TWO);
  assign have1 = (sp != TOP);
  assign have2 = (sp <= LIM2);
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int BW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [2*BW-1:0] req_data,
  output logic          busy,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [2*BW-1:0] rsp_data,
  output logic          ovf_err,
  output logic          unf_err,
  input  logic [PW-1:0] sp,
  input  logic          room1,
  input  logic          room2,
  input  logic          have1,
  input  logic          have2,
  output logic          ptr_dec,
  output logic          ptr_inc,
  output logic          ram_we,
  output logic          ram_re,
  output logic [AW-1:0] ram_addr,
  output logic [BW-1:0] ram_wd,
  input  logic [BW-1:0] ram_q
);
  stk_state_e st_q, st_d;
  stk_op_e    op;
  logic [BW-1:0] lo_q;
  logic wide_q, wide_d, lo_ld;
  logic [BW-1:0] lo_d;
  logic ovf_set, unf_set;
  logic [AW-1:0] push_addr, pull_addr;

  assign op        = stk_op_e'(req_op);
  assign push_addr = AW'(sp - 1'b1);
  assign pull_addr = AW'(sp);

  always_comb begin
    st_d = st_q; wide_d = wide_q; lo_ld = 1'b0; lo_d = lo_q;
    ovf_set = 1'b0; unf_set = 1'b0;
    ptr_dec = 1'b0; ptr_inc = 1'b0;
    ram_we = 1'b0; ram_re = 1'b0; ram_addr = pull_addr; ram_wd = req_data[BW-1:0];
    req_ready = 1'b0; rsp_valid = 1'b0; busy = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          unique case (op)
            OP_PUSH_B: if (room1) begin
              ram_we = 1'b1; ram_addr = push_addr; ptr_dec = 1'b1;
            end else ovf_set = 1'b1;
            OP_PUSH_W: if (room2) begin
              ram_we = 1'b1; ram_addr = push_addr; ram_wd = req_data[2*BW-1:BW];
              ptr_dec = 1'b1; lo_ld = 1'b1; lo_d = req_data[BW-1:0];
              st_d = ST_PUSH_LO;
            end else ovf_set = 1'b1;
            OP_PULL_B: if (have1) begin
              ram_re = 1'b1; ptr_inc = 1'b1; wide_d = 1'b0; st_d = ST_RSP;
            end else unf_set = 1'b1;
            OP_PULL_W: if (have2) begin
              ram_re = 1'b1; ptr_inc = 1'b1; wide_d = 1'b1; st_d = ST_RD_HI;
            end else unf_set = 1'b1;
            default: ;
          endcase
        end
      end
      ST_PUSH_LO: begin
        busy = 1'b1;
        ram_we = 1'b1; ram_addr = push_addr; ram_wd = lo_q; ptr_dec = 1'b1;
        st_d = ST_IDLE;
      end
      ST_RD_HI: begin
        busy = 1'b1;
        lo_ld = 1'b1; lo_d = ram_q;
        ram_re = 1'b1; ptr_inc = 1'b1;
        st_d = ST_RSP;
      end
      ST_RSP: begin
        rsp_valid = 1'b1;
        if (rsp_ready) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign rsp_data = wide_q ? {ram_q, lo_q} : {{BW{1'b0}}, ram_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; wide_q <= 1'b0; lo_q <= '0;
      ovf_err <= 1'b0; unf_err <= 1'b0;
    end else begin
      st_q <= st_d;
      wide_q <= wide_d;
      if (lo_ld) lo_q <= lo_d;
      if (ovf_set) ovf_err <= 1'b1;
      if (unf_set) unf_err <= 1'b1;
    end
  end
endmodule

// File: rtl/hw_stack.sv
module hw_stack #(
  parameter int DEPTH = 64,
  parameter int BW    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_op,
  input  logic [2*BW-1:0] req_data,
  output logic            busy,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [2*BW-1:0] rsp_data,
  output logic            ovf_err,
  output logic            unf_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = $clog2(DEPTH + 1);

  logic [PW-1:0] sp;
  logic room1, room2, have1, have2, ptr_dec, ptr_inc;
  logic ram_we, ram_re;
  logic [AW-1:0] ram_addr;
  logic [BW-1:0] ram_wd, ram_q;

  stk_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .dec(ptr_dec), .inc(ptr_inc), .sp(sp),
    .room1(room1), .room2(room2), .have1(have1), .have2(have2)
  );

  stk_ram #(.DEPTH(DEPTH), .BW(BW)) u_ram (
    .clk(clk), .we(ram_we), .re(ram_re), .addr(ram_addr), .wd(ram_wd), .q(ram_q)
  );

  stk_ctrl #(.DEPTH(DEPTH), .BW(BW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_data(req_data),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .ovf_err(ovf_err), .unf_err(unf_err),
    .sp(sp), .room1(room1), .room2(room2), .have1(have1), .have2(have2),
    .ptr_dec(ptr_dec), .ptr_inc(ptr_inc),
    .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr), .ram_wd(ram_wd), .ram_q(ram_q)
  );
endmodule

// File: rtl/hw_stack_chk.sv
module hw_stack_chk #(
  parameter int BW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [1:0]      req_op,
  input logic            busy,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [2*BW-1:0] rsp_data,
  input logic            ovf_err,
  input logic            unf_err
);
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) ovf_err |=> ovf_err);
  // R7
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) unf_err |=> unf_err);
  // R5
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_err) |-> $past(req_valid && req_ready && (req_op[1] ^ req_op[0])));
  // R6
  unf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unf_err) |-> $past(req_valid && req_ready && !(req_op[1] ^ req_op[0])));
  // R8
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !req_ready);
  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R9
  rsp_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> !req_ready);
endmodule

bind hw_stack hw_stack_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .busy(busy), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .ovf_err(ovf_err), .unf_err(unf_err)
);

// File: tb/hw_stack_tb_top.sv
module hw_stack_tb_top;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b1;
  logic [1:0] req_op = 2'b00;
  logic [15:0] req_data = '0;
  logic req_ready, busy, rsp_valid, ovf_err, unf_err;
  logic [15:0] rsp_data;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;
  logic [7:0] mdl [64];
  int cnt = 0;

  always #4 clk = ~clk;

  hw_stack #(.DEPTH(D), .BW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_data(req_data), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .ovf_err(ovf_err), .unf_err(unf_err)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; cnt = 0;
    @(negedge clk);
  endtask

  task automatic send(input logic [1:0] op, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_data = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pull(input logic [1:0] op, output bit got, output logic [15:0] d);
    send(op, 16'h0);
    got = 0; d = '0;
    for (int k = 0; k < 4; k++) begin
      if (rsp_valid) begin got = 1; d = rsp_data; break; end
      @(negedge clk);
    end
    if (got) @(posedge clk);
  endtask

  task automatic push_b(input logic [7:0] b);
    send(2'b01, {8'h00, b});
    if (cnt < D) begin mdl[cnt] = b; cnt++; end
  endtask

  task automatic push_w(input logic [15:0] w);
    send(2'b10, w);
    if (cnt <= D - 2) begin mdl[cnt] = w[15:8]; mdl[cnt+1] = w[7:0]; cnt += 2; end
  endtask

  initial begin
    bit got;
    logic [15:0] d;
    bit exp_ovf;

    // R1 reset state
    do_reset();
    chk(req_ready === 1'b1, "R1 ready", int'(req_ready), 1);
    chk(busy === 1'b0 && rsp_valid === 1'b0, "R1 busy/rsp", int'({busy, rsp_valid}), 0);
    chk(ovf_err === 1'b0 && unf_err === 1'b0, "R1 flags", int'({ovf_err, unf_err}), 0);
    pull(2'b00, got, d);
    chk(!got && unf_err, "R1 empty after reset (R6)", int'(got), 0);

    // Level sweep: bounds, overflow, LIFO drain, underflow
    for (int lv = 0; lv <= D; lv++) begin
      do_reset();
      for (int i = 0; i < lv; i++) push_b(8'((lv * 31 + i * 7 + 3) & 255));
      chk(ovf_err === 1'b0, "R4 fill without error", int'(ovf_err), 0);
      exp_ovf = (lv > D - 2);
      push_w(16'hA500 | 16'(lv * 17));
      chk(ovf_err === exp_ovf, "R5 word push bound", int'(ovf_err), int'(exp_ovf));
      exp_ovf = exp_ovf || (cnt == D);
      push_b(8'hE1);
      chk(ovf_err === exp_ovf, "R5 byte push bound", int'(ovf_err), int'(exp_ovf));
      while (cnt > 0) begin
        pull(2'b00, got, d);
        cnt--;
        chk(got && d === {8'h00, mdl[cnt]}, "R2 R3 LIFO byte order", int'(d), int'({8'h00, mdl[cnt]}));
      end
      chk(unf_err === 1'b0, "R6 no early underflow", int'(unf_err), 0);
      pull(2'b00, got, d);
      chk(!got && unf_err === 1'b1, "R6 empty pull", int'({got, unf_err}), 1);
      repeat (3) @(negedge clk);
      chk(ovf_err === exp_ovf && unf_err === 1'b1, "R7 sticky flags",
          int'({ovf_err, unf_err}), int'({exp_ovf, 1'b1}));
    end

    // Word traffic at several depths
    for (int nw = 1; nw <= D / 2; nw++) begin
      do_reset();
      for (int i = 0; i < nw; i++) push_w(16'(((i + 1) * 16'h1357) ^ (nw << 12)));
      for (int i = nw - 1; i >= 0; i--) begin
        logic [15:0] e;
        e = 16'(((i + 1) * 16'h1357) ^ (nw << 12));
        pull(2'b11, got, d);
        chk(got && d === e, "R3 word round trip", int'(d), int'(e));
      end
    end

    // R6 word pull with one byte stored leaves it intact
    do_reset();
    push_b(8'h5A);
    pull(2'b11, got, d);
    chk(!got && unf_err === 1'b1, "R6 short word pull", int'({got, unf_err}), 1);
    pull(2'b00, got, d);
    chk(got && d === 16'h005A, "R6 byte kept", int'(d), 16'h005A);

    // R8 busy window of a word push
    do_reset();
    send(2'b10, 16'hBEEF);
    chk(busy === 1'b1 && req_ready === 1'b0, "R8 busy after word push", int'({busy, req_ready}), 2);
    @(negedge clk);
    chk(busy === 1'b0 && req_ready === 1'b1, "R8 busy clears", int'({busy, req_ready}), 1);
    // R8 busy window of a word pull
    send(2'b11, 16'h0);
    chk(busy === 1'b1 && rsp_valid === 1'b0, "R8 busy during word pull", int'({busy, rsp_valid}), 2);
    @(negedge clk);
    chk(rsp_valid === 1'b1 && busy === 1'b0 && rsp_data === 16'hBEEF, "R8 R3 word pull done",
        int'(rsp_data), 16'hBEEF);
    @(posedge clk);

    // R9 back-pressure
    do_reset();
    push_b(8'h3C);
    rsp_ready = 1'b0;
    send(2'b00, 16'h0);
    for (int k = 0; k < 5; k++) begin
      chk(rsp_valid === 1'b1 && rsp_data === 16'h003C && req_ready === 1'b0, "R9 hold under stall",
          int'(rsp_data), 16'h003C);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R9 released", int'({rsp_valid, req_ready}), 1);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule